// File: doc/BRIEF.md
# Page-Addressed Monochrome Display Byte Interpreter

This block sits behind a serial-bus target front end that has already handled addressing and bit timing. The front end hands over written bytes one at a time, each with a valid strobe, and marks the end of every write transaction with a one-cycle end pulse. The block treats the first byte of a transaction as a prefix that selects command or pixel traffic. It executes display commands and stores pixel bytes into an external framebuffer of 132 columns by 8 pages, one byte per column per page.

The block holds the column pointer, the page pointer and four display flags: display enable, inverted video, all-pixels-lit and horizontal mirror. Brightness, clock, charge-pump and geometry commands are accepted. Their argument byte is absorbed without effect, so the byte stream stays in step. Every framebuffer write raises a one-cycle redraw request for the scan-out logic. Malformed prefixes and unknown commands raise a one-cycle error pulse.

Top module: `disp_byte_interp`

## Requirements
- R1: State encoding on `mode_out` is 0 idle, 1 data, 2 command, 3 skip-argument. In idle, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte leaves the block idle and raises `err_pulse` for the one cycle after the strobe.
- R2: In data mode, a byte accepted while the column is below 132 appears in the cycle after its strobe. It is written with `fb_we` high, `fb_addr` = column + page*132 and `fb_wdata` = the byte, together with a one-cycle `redraw_req`. The column then advances by one, and data mode holds until the transaction ends.
- R3: A data byte accepted while the column is 132 or more is dropped: no write, no redraw request, and the column does not change.
- R4: In command mode, exactly one command byte is executed and the block then returns to idle. The exception is a command that takes an argument, which moves it to skip-argument.
- R5: A command in 0x00..0x0F replaces column bits [3:0] with the command's bits [3:0]. A command in 0x10..0x20 replaces column bits [7:4] with the command's bits [3:0].
- R6: A command in 0xB0..0xBF sets the page pointer to the command's bits [2:0].
- R7: Commands 0xA0/0xA1 clear/set mirror, 0xA4/0xA5 clear/set all-on, 0xA6/0xA7 clear/set inverse and 0xAE/0xAF clear/set enable.
- R8: Commands 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB enter skip-argument. The next byte changes no pointer or flag and raises no error, and the block returns to idle.
- R9: Commands 0x40..0x7F (start line, fixed at 0), 0xC0..0xC8 and 0xE3 change nothing and raise no error.
- R10: Any other command byte raises `err_pulse` for one cycle, leaves pointers and flags unchanged and returns the block to idle.
- R11: An `in_end` pulse returns the block to idle from any state. A byte strobed in the same cycle as `in_end` is discarded.
- R12: Synchronous active-high reset clears column, page and all four flags, sets the state to idle, and holds `fb_we`, `redraw_req` and `err_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe from the bus front end |
| in_byte | input | 8 | Received byte |
| in_end | input | 1 | End-of-transaction pulse |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 11 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| redraw_req | output | 1 | One-cycle request to refresh the panel |
| err_pulse | output | 1 | One-cycle protocol or command error |
| disp_en | output | 1 | Display enable flag |
| disp_inv | output | 1 | Inverted video flag |
| disp_allon | output | 1 | All-pixels-lit flag |
| disp_mirror | output | 1 | Horizontal mirror flag |
| mode_out | output | 2 | Interpreter state (R1 encoding) |
| col_out | output | 8 | Column pointer |
| page_out | output | 3 | Page pointer |

## Verification
Four properties are checked on every cycle: the return to idle after an end pulse, the single-byte lifetime of command and skip states, the column bound and increment around each write, and the error-with-no-change rule for unknown commands. Other behaviour can only be shown by driving byte sequences at the ports. The bench sweeps all 256 values in the command position, all 254 invalid prefixes, a full page row past the column limit, nibble splits of the column, and a byte that arrives together with an end pulse.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    localparam int COL_W = 8;

    localparam logic [7:0] PFX_CMD  = 8'h80;
    localparam logic [7:0] PFX_DATA = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CMD  = 2'd2,
        ST_SKIP = 2'd3
    } dbi_state_e;

    typedef enum logic [2:0] {
        OP_COL_LO,
        OP_COL_HI,
        OP_PAGE,
        OP_FLAG,
        OP_SKIP_ARG,
        OP_NOP,
        OP_BAD
    } dbi_op_e;

    typedef enum logic [1:0] {
        FL_MIRROR,
        FL_ALLON,
        FL_INVERT,
        FL_ENABLE
    } dbi_flag_e;

    typedef struct packed {
        dbi_op_e   op;
        dbi_flag_e flag;
        logic      val;
        logic [3:0] nib;
    } dbi_cmd_t;

    typedef struct packed {
        logic enable;
        logic invert;
        logic allon;
        logic mirror;
    } dbi_flags_t;

    function automatic dbi_cmd_t dbi_decode(input logic [7:0] b);
        dbi_cmd_t c;
        c.op   = OP_BAD;
        c.flag = FL_MIRROR;
        c.val  = b[0];
        c.nib  = b[3:0];
        if (b <= 8'h0F)
            c.op = OP_COL_LO;
        else if (b <= 8'h20)
            c.op = OP_COL_HI;
        else if (b >= 8'h40 && b <= 8'h7F)
            c.op = OP_NOP;
        else if (b >= 8'hB0 && b <= 8'hBF)
            c.op = OP_PAGE;
        else if (b >= 8'hC0 && b <= 8'hC8)
            c.op = OP_NOP;
        else begin
            case (b)
                8'hA0, 8'hA1: begin c.op = OP_FLAG; c.flag = FL_MIRROR; end
                8'hA4, 8'hA5: begin c.op = OP_FLAG; c.flag = FL_ALLON;  end
                8'hA6, 8'hA7: begin c.op = OP_FLAG; c.flag = FL_INVERT; end
                8'hAE, 8'hAF: begin c.op = OP_FLAG; c.flag = FL_ENABLE; end
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB: c.op = OP_SKIP_ARG;
                8'hE3:   c.op = OP_NOP;
                default: c.op = OP_BAD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/dbi_decoder.sv
module dbi_decoder
    import dbi_pkg::*;
(
    input  logic [7:0] byte_i,
    output dbi_cmd_t   cmd_o
);
    always_comb begin
        cmd_o = dbi_decode(byte_i);
    end
endmodule

// File: rtl/dbi_sequencer.sv
module dbi_sequencer
    import dbi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_end,
    input  dbi_cmd_t   cmd,
    output dbi_state_e state_q,
    output logic       data_fire,
    output logic       cmd_fire,
    output logic       pfx_err
);
    dbi_state_e state_d;
    logic       take;

    always_comb begin
        take      = in_valid && !in_end;
        data_fire = take && (state_q == ST_DATA);
        cmd_fire  = take && (state_q == ST_CMD);
        pfx_err   = take && (state_q == ST_IDLE) &&
                    (in_byte != PFX_CMD) && (in_byte != PFX_DATA);
    end

    always_comb begin
        state_d = state_q;
        if (in_end) begin
            state_d = ST_IDLE;
        end else if (in_valid) begin
            case (state_q)
                ST_IDLE: begin
                    if (in_byte == PFX_CMD)       state_d = ST_CMD;
                    else if (in_byte == PFX_DATA) state_d = ST_DATA;
                    else                          state_d = ST_IDLE;
                end
                ST_DATA: state_d = ST_DATA;
                ST_CMD:  state_d = (cmd.op == OP_SKIP_ARG) ? ST_SKIP : ST_IDLE;
                ST_SKIP: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R11
    a_r11_end_idle: assert property (@(posedge clk) disable iff (rst)
        in_end |=> state_q == ST_IDLE);

    // R4
    a_r4_cmd_single: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CMD && in_valid) |=> (state_q == ST_IDLE || state_q == ST_SKIP));

    // R8
    a_r8_skip_one: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SKIP && in_valid) |=> state_q == ST_IDLE);

    // R2
    a_r2_data_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !in_end) |=> state_q == ST_DATA);

endmodule

// File: rtl/dbi_regs.sv
module dbi_regs
    import dbi_pkg::*;
#(
    parameter int COLS   = 132,
    parameter int PAGES  = 8,
    parameter int PAGE_W = $clog2(PAGES),
    parameter int ADDR_W = $clog2(COLS * PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_fire,
    input  logic              cmd_fire,
    input  dbi_cmd_t          cmd,
    input  logic [7:0]        in_byte,
    input  logic              pfx_err,
    output logic [COL_W-1:0]  col_q,
    output logic [PAGE_W-1:0] page_q,
    output dbi_flags_t        flags_q,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [7:0]        fb_wdata,
    output logic              redraw,
    output logic              err
);
    localparam logic [COL_W-1:0]  COL_LIMIT = COL_W'(COLS);
    localparam logic [ADDR_W-1:0] ROW_SPAN  = ADDR_W'(COLS);

    logic              in_range;
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr;

    always_comb begin
        in_range = col_q < COL_LIMIT;
        wr_go    = data_fire && in_range;
        wr_addr  = ADDR_W'(col_q) + ADDR_W'(page_q) * ROW_SPAN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= '0;
            page_q  <= '0;
            flags_q <= '0;
        end else if (wr_go) begin
            col_q <= col_q + 1'b1;
        end else if (cmd_fire) begin
            case (cmd.op)
                OP_COL_LO: col_q[3:0] <= cmd.nib;
                OP_COL_HI: col_q[7:4] <= cmd.nib;
                OP_PAGE:   page_q     <= cmd.nib[PAGE_W-1:0];
                OP_FLAG: begin
                    case (cmd.flag)
                        FL_MIRROR: flags_q.mirror <= cmd.val;
                        FL_ALLON:  flags_q.allon  <= cmd.val;
                        FL_INVERT: flags_q.invert <= cmd.val;
                        FL_ENABLE: flags_q.enable <= cmd.val;
                        default:   flags_q        <= flags_q;
                    endcase
                end
                default: col_q <= col_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_we    <= 1'b0;
            fb_addr  <= '0;
            fb_wdata <= '0;
            redraw   <= 1'b0;
            err      <= 1'b0;
        end else begin
            fb_we  <= wr_go;
            redraw <= wr_go;
            err    <= pfx_err || (cmd_fire && cmd.op == OP_BAD);
            if (wr_go) begin
                fb_addr  <= wr_addr;
                fb_wdata <= in_byte;
            end
        end
    end

    // R3
    a_r3_no_write_past_end: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> $past(col_q) < COL_LIMIT);

    // R2
    a_r2_col_advance: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> col_q == $past(col_q) + 1'b1);

    // R10
    a_r10_bad_no_change: assert property (@(posedge clk) disable iff (rst)
        (cmd_fire && cmd.op == OP_BAD) |=> (err && $stable(flags_q) && $stable(col_q) && $stable(page_q)));

endmodule

// File: rtl/disp_byte_interp.sv
module disp_byte_interp
    import dbi_pkg::*;
#(
    parameter int COLS   = 132,
    parameter int PAGES  = 8,
    parameter int PAGE_W = $clog2(PAGES),
    parameter int ADDR_W = $clog2(COLS * PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_end,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [7:0]        fb_wdata,
    output logic              redraw_req,
    output logic              err_pulse,
    output logic              disp_en,
    output logic              disp_inv,
    output logic              disp_allon,
    output logic              disp_mirror,
    output logic [1:0]        mode_out,
    output logic [7:0]        col_out,
    output logic [PAGE_W-1:0] page_out
);
    dbi_cmd_t   cmd;
    dbi_state_e state;
    dbi_flags_t flags;
    logic       data_fire;
    logic       cmd_fire;
    logic       pfx_err;

    dbi_decoder u_dec (
        .byte_i (in_byte),
        .cmd_o  (cmd)
    );

    dbi_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_end    (in_end),
        .cmd       (cmd),
        .state_q   (state),
        .data_fire (data_fire),
        .cmd_fire  (cmd_fire),
        .pfx_err   (pfx_err)
    );

    dbi_regs #(
        .COLS   (COLS),
        .PAGES  (PAGES),
        .PAGE_W (PAGE_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .data_fire (data_fire),
        .cmd_fire  (cmd_fire),
        .cmd       (cmd),
        .in_byte   (in_byte),
        .pfx_err   (pfx_err),
        .col_q     (col_out),
        .page_q    (page_out),
        .flags_q   (flags),
        .fb_we     (fb_we),
        .fb_addr   (fb_addr),
        .fb_wdata  (fb_wdata),
        .redraw    (redraw_req),
        .err       (err_pulse)
    );

    always_comb begin
        mode_out    = state;
        disp_en     = flags.enable;
        disp_inv    = flags.invert;
        disp_allon  = flags.allon;
        disp_mirror = flags.mirror;
    end

endmodule

// File: tb/disp_byte_interp_test.sv
module disp_byte_interp_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_end = 1'b0;
    logic        fb_we;
    logic [10:0] fb_addr;
    logic [7:0]  fb_wdata;
    logic        redraw_req;
    logic        err_pulse;
    logic        disp_en, disp_inv, disp_allon, disp_mirror;
    logic [1:0]  mode_out;
    logic [7:0]  col_out;
    logic [2:0]  page_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int m_col, m_page;
    bit m_en, m_inv, m_all, m_mir;

    always #10 clk = ~clk;

    disp_byte_interp uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_end(in_end),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata), .redraw_req(redraw_req),
        .err_pulse(err_pulse), .disp_en(disp_en), .disp_inv(disp_inv),
        .disp_allon(disp_allon), .disp_mirror(disp_mirror), .mode_out(mode_out),
        .col_out(col_out), .page_out(page_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic end_txn();
        @(negedge clk);
        in_end = 1'b1;
        @(negedge clk);
        in_end = 1'b0;
    endtask

    function automatic bit arg_cmd(input int b);
        return b == 'h81 || b == 'hA8 || b == 'hAD || b == 'hD3 || b == 'hD5 ||
               b == 'hD8 || b == 'hD9 || b == 'hDA || b == 'hDB;
    endfunction

    function automatic bit known_cmd(input int b);
        if (b < 'h21) return 1;
        if (b >= 'h40 && b < 'h80) return 1;
        if (b >= 'hB0 && b < 'hC0) return 1;
        if (b >= 'hC0 && b < 'hC9) return 1;
        if (b == 'hE3) return 1;
        if (b == 'hA0 || b == 'hA1 || b == 'hA4 || b == 'hA5 || b == 'hA6 ||
            b == 'hA7 || b == 'hAE || b == 'hAF) return 1;
        return arg_cmd(b);
    endfunction

    task automatic model_cmd(input int b);
        if (b < 'h10)                    m_col = (m_col & 'hF0) | (b % 16);
        else if (b < 'h21)               m_col = (m_col % 16) | ((b % 16) * 16);
        else if (b >= 'hB0 && b < 'hC0)  m_page = b % 8;
        else if (b == 'hA0 || b == 'hA1) m_mir = b[0];
        else if (b == 'hA4 || b == 'hA5) m_all = b[0];
        else if (b == 'hA6 || b == 'hA7) m_inv = b[0];
        else if (b == 'hAE || b == 'hAF) m_en  = b[0];
    endtask

    task automatic chk_state(input string req);
        chk(col_out == m_col[7:0], req, col_out, m_col);
        chk(page_out == m_page[2:0], req, page_out, m_page);
        chk({disp_en, disp_inv, disp_allon, disp_mirror} == {m_en, m_inv, m_all, m_mir},
            req, {disp_en, disp_inv, disp_allon, disp_mirror}, {m_en, m_inv, m_all, m_mir});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_col = 0; m_page = 0; m_en = 0; m_inv = 0; m_all = 0; m_mir = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(mode_out == 2'd0, "R12", mode_out, 0);
        chk(!fb_we && !redraw_req && !err_pulse, "R12", fb_we, 0);
        chk_state("R12");

        // R4 R5 R6 R7 R8 R9 R10: every byte in the command position
        for (int c = 0; c < 256; c++) begin
            send(8'h80);
            chk(mode_out == 2'd2, "R1", mode_out, 2);
            send(c[7:0]);
            chk(err_pulse == !known_cmd(c), "R10", err_pulse, !known_cmd(c));
            chk(fb_we == 1'b0, "R4", fb_we, 0);
            model_cmd(c);
            chk(mode_out == (arg_cmd(c) ? 2'd3 : 2'd0), "R4", mode_out, arg_cmd(c) ? 3 : 0);
            chk_state("R5");
            if (arg_cmd(c)) begin
                send(m_en ? 8'hAE : 8'hAF);   // R8 argument must be swallowed
                chk(mode_out == 2'd0, "R8", mode_out, 0);
                chk(err_pulse == 1'b0, "R8", err_pulse, 0);
                chk_state("R8");
            end
        end

        // R1 invalid prefixes
        for (int b = 0; b < 256; b++) begin
            if (b != 'h80 && b != 'h40) begin
                send(b[7:0]);
                chk(err_pulse == 1'b1 && mode_out == 2'd0, "R1", {err_pulse, mode_out}, 4);
            end
        end

        // R2 R3 full row on page 5 from column 0
        send(8'h80); send(8'hB5); send(8'h80); send(8'h00); send(8'h80); send(8'h10);
        m_page = 5; m_col = 0;
        chk_state("R6");
        send(8'h40);
        chk(mode_out == 2'd1, "R1", mode_out, 1);
        for (int i = 0; i < 140; i++) begin
            send(8'(i ^ 'h5A));
            if (i < 132) begin
                chk(fb_we && redraw_req, "R2", fb_we, 1);
                chk(fb_addr == 11'(5 * 132 + i), "R2", fb_addr, 5 * 132 + i);
                chk(fb_wdata == 8'(i ^ 'h5A), "R2", fb_wdata, (i ^ 'h5A) & 255);
            end else begin
                chk(!fb_we && !redraw_req, "R3", fb_we, 0);
                chk(col_out == 8'd132, "R3", col_out, 132);
            end
            chk(mode_out == 2'd1, "R2", mode_out, 1);
        end
        end_txn();
        chk(mode_out == 2'd0, "R11", mode_out, 0);

        // R5 nibble split: column 0x83 = 131, one write then drop
        send(8'h80); send(8'h18); send(8'h80); send(8'h03);
        chk(col_out == 8'h83, "R5", col_out, 'h83);
        send(8'h40);
        send(8'hC3);
        chk(fb_we && fb_addr == 11'(5 * 132 + 131), "R3", fb_addr, 5 * 132 + 131);
        send(8'hC4);
        chk(!fb_we, "R3", fb_we, 0);

        // R11 byte alongside end pulse is discarded
        send(8'h01);
        end_txn();
        send(8'h40);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h77; in_end = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_end = 1'b0;
        chk(!fb_we && mode_out == 2'd0, "R11", {fb_we, mode_out}, 0);
        send(8'h80);
        end_txn();
        chk(mode_out == 2'd0, "R11", mode_out, 0);

        // R12 reset clears a populated state
        send(8'h80); send(8'hAF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_col = 0; m_page = 0; m_en = 0; m_inv = 0; m_all = 0; m_mir = 0;
        chk(mode_out == 2'd0, "R12", mode_out, 0);
        chk_state("R12");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule